// File: doc/BRIEF.md
# ALU Flag Generator and Status Register

This block pairs a combinational 8-bit arithmetic and logic unit with the status byte that records its flags. Each cycle it produces a result from two operands and a 3-bit operation code. When the flag-update enable is high, the next clock edge stores the zero flag. For an add or a subtract that same edge also stores the carry and the digit carry. Subtraction adds the two's complement of the second operand, so the carry bit reads as an inverted borrow.

The same byte holds three more bits. Two are event-driven indicators: one marks power-down and is cleared by a sleep event, and the other marks a watchdog timeout and is cleared by a timeout event. A watchdog clear sets both of them, and so does reset. The third is a memory bank select, which software can write over a register-bus write port. The bus can also write the three arithmetic flags. It cannot reach the two indicator bits or the two top bits, which always read 0.

Status byte layout: bit 0 carry, bit 1 digit carry, bit 2 zero, bit 3 power-down indicator, bit 4 timeout indicator, bit 5 bank select, bits 7:6 zero.

Top module: `alu_status_reg`

## Requirements
- R1: `result` follows `op_sel` with no clock delay. The codes are: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, 5 passes a, 6 passes b, and 7 gives NOT a. Arithmetic results are truncated to 8 bits.
- R2: An add (code 0) with `flag_en` high sets status bit 0 at the next edge if a+b exceeds 255, and clears it otherwise.
- R3: A subtract (code 1) with `flag_en` high sets status bit 0 if a >= b (no borrow), and clears it if a < b (borrow).
- R4: An add or subtract with `flag_en` high updates status bit 1. For an add it is 1 when the sum of the low nibbles exceeds 15. For a subtract it is 1 when the low nibble of a is >= the low nibble of b.
- R5: Any operation with `flag_en` high sets status bit 2 to 1 when `result` is zero, and to 0 otherwise.
- R6: A logic or pass operation (codes 2 to 7) with `flag_en` high leaves bits 1:0 unchanged.
- R7: With `flag_en` and `bus_wr` both low, bits 2:0 keep their value.
- R8: `sleep_evt` clears bit 3. `wdt_timeout` clears bit 4. `wdt_clear` sets both bits. When a clearing event and `wdt_clear` occur in the same cycle, the clearing event wins for its own bit.
- R9: After reset, the status byte is 0x18.
- R10: `bus_wr` loads bits 0, 1, 2 and 5 from `bus_wdata`. A flag update in the same cycle overrides the bus value for the flags that the update writes. `bank_sel` always equals bit 5.
- R11: Bus writes to bits 3, 4, 6 and 7 are ignored, and bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_sel | input | 3 | Operation code |
| flag_en | input | 1 | Store the flags of this cycle's operation |
| sleep_evt | input | 1 | Sleep event; clears the power-down indicator |
| wdt_timeout | input | 1 | Watchdog timeout; clears the timeout indicator |
| wdt_clear | input | 1 | Watchdog clear; sets both indicators |
| bus_wr | input | 1 | Register-bus write strobe for the status byte |
| bus_wdata | input | 8 | Register-bus write data |
| result | output | 8 | Operation result |
| status | output | 8 | Status byte |
| bank_sel | output | 1 | Data bank select |

## Verification
`result` is combinational, so the bench checks it in the same cycle that the operands and code are driven. Every status bit moves exactly one edge after the inputs that cause it. The bench drives inputs on the falling edge and computes the next status value behaviourally from those inputs. After the following rising edge, it compares that value against the status byte field by field at the next falling edge. The stimulus includes directed carry, borrow, nibble-boundary and zero cases. Random cycles mix in simultaneous bus writes, flag updates and the three watchdog and sleep events.

// File: rtl/alu_status_reg.sv
module alu_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   op_sel,
  input  logic         flag_en,
  input  logic         sleep_evt,
  input  logic         wdt_timeout,
  input  logic         wdt_clear,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  output logic [W-1:0] result,
  output logic [7:0]   status,
  output logic         bank_sel
);
  localparam int H = W / 2;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_PA = 3'd5, OP_PB = 3'd6, OP_NOTA = 3'd7;

  logic         is_sub, is_arith;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [H:0]   lo_sum;
  logic         c_q, dc_q, z_q, pd_q, to_q, bank_q;

  assign is_sub   = (op_sel == OP_SUB);
  assign is_arith = (op_sel == OP_ADD) || is_sub;
  assign b_eff    = is_sub ? ~op_b : op_b;
  assign sum      = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign lo_sum   = {1'b0, op_a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, is_sub};

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB: result = sum[W-1:0];
      OP_AND:         result = op_a & op_b;
      OP_OR:          result = op_a | op_b;
      OP_XOR:         result = op_a ^ op_b;
      OP_PA:          result = op_a;
      OP_PB:          result = op_b;
      default:        result = ~op_a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q    <= 1'b0;
      dc_q   <= 1'b0;
      z_q    <= 1'b0;
      bank_q <= 1'b0;
      pd_q   <= 1'b1;
      to_q   <= 1'b1;
    end else begin
      if (bus_wr) begin
        c_q    <= bus_wdata[0];
        dc_q   <= bus_wdata[1];
        z_q    <= bus_wdata[2];
        bank_q <= bus_wdata[5];
      end
      if (flag_en) begin
        z_q <= (result == '0);
        if (is_arith) begin
          c_q  <= sum[W];
          dc_q <= lo_sum[H];
        end
      end
      if (wdt_clear) begin
        pd_q <= 1'b1;
        to_q <= 1'b1;
      end
      if (sleep_evt)   pd_q <= 1'b0;
      if (wdt_timeout) to_q <= 1'b0;
    end
  end

  assign status   = {2'b00, bank_q, to_q, pd_q, z_q, dc_q, c_q};
  assign bank_sel = bank_q;

  a_r8_sleep_clears_pd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt |=> !status[3]);
  a_r8_timeout_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !status[4]);
  a_r11_bus_no_indicators: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sleep_evt && !wdt_timeout && !wdt_clear) |=> $stable(status[4:3]));
  a_r6_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !bus_wr && op_sel > OP_SUB) |=> $stable(status[1:0]));
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (status[2] == ($past(result) == '0)));
  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_sub) |=> (status[0] == ($past(op_a) >= $past(op_b))));
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en && !bus_wr) |=> $stable(status[2:0]));
endmodule

// File: tb/tb_alu_status_reg.sv
module tb_alu_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0, op_b = '0, bus_wdata = '0;
  logic [2:0] op_sel = '0;
  logic       flag_en = 1'b0, sleep_evt = 1'b0, wdt_timeout = 1'b0, wdt_clear = 1'b0, bus_wr = 1'b0;
  logic [7:0] result, status;
  logic       bank_sel;

  int checks = 0;
  int errors = 0;
  int exp_st = 'h18;

  always #4 clk = ~clk;

  alu_status_reg dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_en(flag_en), .sleep_evt(sleep_evt), .wdt_timeout(wdt_timeout),
    .wdt_clear(wdt_clear), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .result(result), .status(status), .bank_sel(bank_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_result(int a, int b, int op);
    case (op)
      0: return (a + b) % 256;
      1: return (a - b + 256) % 256;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a;
      6: return b;
      default: return 255 - a;
    endcase
  endfunction

  task automatic check_status();
    chk("R2 R3 R4 R6 carry/digit", status & 3, exp_st & 3);
    chk("R5 R7 zero", (status >> 2) & 1, (exp_st >> 2) & 1);
    chk("R8 indicators", (status >> 3) & 3, (exp_st >> 3) & 3);
    chk("R10 bank", (status >> 5) & 1, (exp_st >> 5) & 1);
    chk("R10 bank_sel", bank_sel, (exp_st >> 5) & 1);
    chk("R11 top bits", status >> 6, 0);
  endtask

  task automatic step(input int a, input int b, input int op, input bit fe,
                      input bit bw, input int wd, input bit sl, input bit to, input bit wc);
    int r, c, dc, z, pd, tob, bk, nxt;
    @(negedge clk);
    check_status();
    op_a = 8'(a); op_b = 8'(b); op_sel = 3'(op); flag_en = fe; bus_wr = bw;
    bus_wdata = 8'(wd); sleep_evt = sl; wdt_timeout = to; wdt_clear = wc;
    #1;
    r = model_result(a, b, op);
    chk("R1 result", result, r);
    c = exp_st & 1; dc = (exp_st >> 1) & 1; z = (exp_st >> 2) & 1;
    pd = (exp_st >> 3) & 1; tob = (exp_st >> 4) & 1; bk = (exp_st >> 5) & 1;
    if (bw) begin
      c = wd & 1; dc = (wd >> 1) & 1; z = (wd >> 2) & 1; bk = (wd >> 5) & 1;
    end
    if (fe) begin
      z = (r == 0);
      if (op == 0) begin
        c = (a + b) > 255;
        dc = ((a % 16) + (b % 16)) > 15;
      end else if (op == 1) begin
        c = (a >= b);
        dc = ((a % 16) >= (b % 16));
      end
    end
    if (wc) begin pd = 1; tob = 1; end
    if (sl) pd = 0;
    if (to) tob = 0;
    nxt = c + dc * 2 + z * 4 + pd * 8 + tob * 16 + bk * 32;
    exp_st = nxt;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset status", status, 'h18);
    rst_n = 1'b1;
    // R2 R4 R5: 0xFF+0x01 wraps to 0 with both carries
    step(8'hFF, 8'h01, 0, 1, 0, 0, 0, 0, 0);
    // R3 R4: equal operands give no borrow, zero result
    step(8'h05, 8'h05, 1, 1, 0, 0, 0, 0, 0);
    // R3: borrow case 3-5
    step(8'h03, 8'h05, 1, 1, 0, 0, 0, 0, 0);
    // R4: nibble boundary 0x08+0x08, 0x10-0x01
    step(8'h08, 8'h08, 0, 1, 0, 0, 0, 0, 0);
    step(8'h10, 8'h01, 1, 1, 0, 0, 0, 0, 0);
    // R6: logic op leaves carries, sets zero
    step(8'hF0, 8'h0F, 2, 1, 0, 0, 0, 0, 0);
    // R7: no enable, flags hold
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    // R10 R11: bus write all ones; indicators and top bits ignored
    step(8'h01, 8'h01, 0, 0, 1, 8'hFF, 0, 0, 0);
    step(8'h01, 8'h01, 0, 0, 1, 8'h00, 0, 0, 0);
    // R10: flag update overrides bus write
    step(8'h80, 8'h80, 0, 1, 1, 8'h20, 0, 0, 0);
    // R8: sleep, timeout, clear, and collision with clear
    step(0, 0, 5, 0, 0, 0, 1, 0, 0);
    step(0, 0, 5, 0, 0, 0, 0, 1, 0);
    step(0, 0, 5, 0, 0, 0, 0, 0, 1);
    step(0, 0, 5, 0, 0, 0, 1, 1, 1);
    step(0, 0, 5, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7),
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 255),
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
    end
    step(0, 0, 5, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_status();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule